// File: doc/BRIEF.md
# Serial Byte Double-Buffer with Overrun and Underflow Flags

This block sits between the bit-level datapath of a two-wire serial controller and the CPU register file. On the receive side, serial bits arrive most significant bit first, one per `rx_bit_vld` pulse, into a shift register. Each completed byte is copied into a holding register that the CPU reads. If the CPU has not yet read the previous byte, the block flags an overrun instead of copying. On the transmit side, the CPU writes a holding register. Its content moves into a transmit shifter, which sends one bit per `tx_bit_adv` pulse.

If the shifter finishes a byte and the holding register has not been rewritten since the last transfer, the block signals underflow. The `tx_not_empty` flag drops to 0 and the shifter sends the same byte again.

Receive control is a three-state machine:
- `RX_EMPTY`: no unread byte.
- `RX_FULL`: an unread byte is in the holding register.
- `RX_OVR`: an unread byte plus a pending byte in the shifter.

Its transitions are:
- Capture: EMPTY to FULL.
- Consume: FULL to EMPTY.
- Overrun: FULL to OVR.
- Drain: OVR to FULL.

Transmit control has three states:
- `TX_IDLE`: nothing transferred yet.
- `TX_SEND`: sending fresh data.
- `TX_REPEAT`: retransmitting after underflow.

Its transitions are:
- Start: IDLE to SEND.
- Reload: SEND or REPEAT to SEND.
- Starve: SEND or REPEAT to REPEAT.

Top module: `serial_byte_buffer`

## Requirements
- R1: Received bits shift in MSB first, one per cycle with `rx_bit_vld`=1. `rx_byte_done` is high for exactly the cycle after the 8th bit is clocked. If no unread byte is held, the completed byte appears on `rx_data` in that same cycle.
- R2: A byte that completes while an unread byte is held, with no `rx_cpu_rd` in that cycle, sets `rx_overrun` to 1 in the next cycle. A completion in the same cycle as a `rx_cpu_rd` replaces the holding register instead.
- R3: While `rx_overrun` is 1, `rx_data` does not change unless `rx_cpu_rd` is high. Further arriving bits keep shifting into, and overwriting, the receive shifter.
- R4: `rx_cpu_rd` during overrun clears `rx_overrun` and loads the shifter byte into `rx_data` at the same edge. If a byte completes in that cycle, the completed byte is loaded instead. `rx_dbg_rd` has no effect on any output.
- R5: After reset:
  - `rx_data` is 0.
  - `rx_overrun` is 0.
  - `rx_byte_done` is 0.
  - `tx_not_empty` is 1.
  - `tx_bit` is 0.
  - `tx_byte_req` is 0.
- R6: In TX_IDLE, a written byte moves to the shifter at the next edge. The shifter then drives bit 7 on `tx_bit` and advances one bit, toward bit 0, per `tx_bit_adv`. `tx_bit` is 0 in TX_IDLE.
- R7: After the 8th `tx_bit_adv` of a byte with no fresh data available, `tx_not_empty` becomes 0 and the same byte is sent again from bit 7.
- R8: Any `tx_cpu_wr` sets `tx_not_empty` to 1 at the next edge. A write in the same cycle as the 8th advance counts as in time and is transferred at once.
- R9: A write during sending waits in the holding register until the current byte's 8th advance. `tx_byte_req` pulses high for one cycle after every holding-to-shifter transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low module reset |
| rx_bit_vld | input | 1 | A serial bit is present on rx_bit |
| rx_bit | input | 1 | Serial receive bit |
| rx_cpu_rd | input | 1 | Functional CPU read of the receive holding register |
| rx_dbg_rd | input | 1 | Debug read of the receive holding register |
| rx_data | output | 8 | Receive holding register |
| rx_overrun | output | 1 | Receive overrun flag |
| rx_byte_done | output | 1 | Byte-complete strobe |
| tx_cpu_wr | input | 1 | CPU write of the transmit holding register |
| tx_wr_data | input | 8 | Write data |
| tx_bit_adv | input | 1 | Advance the transmit shifter by one bit |
| tx_bit | output | 1 | Current serial transmit bit |
| tx_not_empty | output | 1 | 1 = no underflow, 0 = underflow |
| tx_byte_req | output | 1 | Strobe after each holding-to-shifter transfer |

## Verification
A receive state machine stuck in the wrong state shows up within one cycle of the next byte completion or CPU read. The symptom is a wrong `rx_overrun` value, or an `rx_data` that changes when it must not or stays when it must load. A wrong transmit bit index or state shows up on `tx_bit` at the very next advance. A lost fresh-data marker shows up at the next byte boundary, as a wrong `tx_not_empty` or a repeated or missing `tx_byte_req`. Every output is compared each cycle against a model built from the requirements, so any divergence is caught on the cycle it first reaches a port.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    typedef enum logic [1:0] {
        RX_EMPTY = 2'd0,
        RX_FULL  = 2'd1,
        RX_OVR   = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_SEND   = 2'd1,
        TX_REPEAT = 2'd2
    } tx_state_e;
endpackage

// File: rtl/sbuf_rx.sv
module sbuf_rx
    import sbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              cpu_rd,
    input  logic              dbg_rd,
    output logic [DATA_W-1:0] hold_data,
    output logic              overrun,
    output logic              byte_done
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    rx_state_e         st_q, st_d;
    logic [DATA_W-1:0] sr_q, hold_q, src;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q, complete, ld_hold;
    logic [DATA_W-1:0] new_byte;

    assign complete = bit_vld && (cnt_q == LAST);
    assign new_byte = {sr_q[DATA_W-2:0], bit_in};

    // next state and holding-register load decision
    always_comb begin
        st_d    = st_q;
        ld_hold = 1'b0;
        src     = new_byte;
        unique case (st_q)
            RX_EMPTY: begin
                if (complete) begin
                    ld_hold = 1'b1;
                    st_d    = RX_FULL;
                end
            end
            RX_FULL: begin
                if (complete) begin
                    if (cpu_rd) ld_hold = 1'b1;
                    else        st_d    = RX_OVR;
                end else if (cpu_rd) begin
                    st_d = RX_EMPTY;
                end
            end
            RX_OVR: begin
                if (cpu_rd) begin
                    ld_hold = 1'b1;
                    src     = complete ? new_byte : sr_q;
                    st_d    = RX_FULL;
                end
            end
            default: st_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            hold_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= complete;
            if (bit_vld) begin
                sr_q  <= new_byte;
                cnt_q <= complete ? '0 : cnt_q + 1'b1;
            end
            if (ld_hold) hold_q <= src;
        end
    end

    always_comb begin
        hold_data = hold_q;
        overrun   = (st_q == RX_OVR);
        byte_done = done_q;
    end

    p_ovr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_FULL && complete && !cpu_rd) |=> overrun);
    p_hold_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_OVR && !cpu_rd) |=> $stable(hold_data));
    p_ovr_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_OVR && cpu_rd) |=> (!overrun && st_q == RX_FULL));
    p_dbg_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_OVR && dbg_rd && !cpu_rd) |=> overrun);
    p_done_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && cnt_q == LAST) |=> byte_done);
endmodule

// File: rtl/sbuf_tx.sv
module sbuf_tx
    import sbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit_adv,
    output logic              tx_bit,
    output logic              not_empty,
    output logic              byte_req
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    tx_state_e         st_q, st_d;
    logic [DATA_W-1:0] hold_q, sr_q, next_data;
    logic [CNT_W-1:0]  idx_q;
    logic              fresh_q, ok_q, req_q;
    logic              avail, boundary, xfer, starve;

    assign avail     = fresh_q | cpu_wr;
    assign next_data = cpu_wr ? wr_data : hold_q;
    assign boundary  = bit_adv && (idx_q == LAST);

    always_comb begin
        st_d   = st_q;
        xfer   = 1'b0;
        starve = 1'b0;
        unique case (st_q)
            TX_IDLE: begin
                if (avail) begin
                    xfer = 1'b1;
                    st_d = TX_SEND;
                end
            end
            TX_SEND, TX_REPEAT: begin
                if (boundary) begin
                    if (avail) begin
                        xfer = 1'b1;
                        st_d = TX_SEND;
                    end else begin
                        starve = 1'b1;
                        st_d   = TX_REPEAT;
                    end
                end
            end
            default: st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            sr_q    <= '0;
            idx_q   <= '0;
            fresh_q <= 1'b0;
            ok_q    <= 1'b1;
            req_q   <= 1'b0;
        end else begin
            req_q <= xfer;
            if (cpu_wr) hold_q <= wr_data;
            if (xfer)        fresh_q <= 1'b0;
            else if (cpu_wr) fresh_q <= 1'b1;
            if (xfer) sr_q <= next_data;
            if (xfer || starve)                idx_q <= '0;
            else if (st_q != TX_IDLE && bit_adv) idx_q <= idx_q + 1'b1;
            if (cpu_wr)      ok_q <= 1'b1;
            else if (starve) ok_q <= 1'b0;
        end
    end

    always_comb begin
        tx_bit    = (st_q == TX_IDLE) ? 1'b0 : sr_q[LAST - idx_q];
        not_empty = ok_q;
        byte_req  = req_q;
    end

    p_retransmit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != TX_IDLE && boundary && !avail) |=> (!not_empty && $stable(sr_q)));
    p_write_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> not_empty);
    p_wait_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != TX_IDLE && !boundary) |=> !byte_req);
    p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_IDLE && avail) |=> (byte_req && st_q == TX_SEND));
endmodule

// File: rtl/serial_byte_buffer.sv
module serial_byte_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit_vld,
    input  logic              rx_bit,
    input  logic              rx_cpu_rd,
    input  logic              rx_dbg_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_overrun,
    output logic              rx_byte_done,
    input  logic              tx_cpu_wr,
    input  logic [DATA_W-1:0] tx_wr_data,
    input  logic              tx_bit_adv,
    output logic              tx_bit,
    output logic              tx_not_empty,
    output logic              tx_byte_req
);
    sbuf_rx #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (rx_bit_vld),
        .bit_in    (rx_bit),
        .cpu_rd    (rx_cpu_rd),
        .dbg_rd    (rx_dbg_rd),
        .hold_data (rx_data),
        .overrun   (rx_overrun),
        .byte_done (rx_byte_done)
    );

    sbuf_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (tx_cpu_wr),
        .wr_data   (tx_wr_data),
        .bit_adv   (tx_bit_adv),
        .tx_bit    (tx_bit),
        .not_empty (tx_not_empty),
        .byte_req  (tx_byte_req)
    );
endmodule

// File: tb/test_serial_byte_buffer.sv
module test_serial_byte_buffer;
    localparam time CYC = 8ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit_vld = 0, rx_bit = 0, rx_cpu_rd = 0, rx_dbg_rd = 0;
    logic [7:0] rx_data;
    logic       rx_overrun, rx_byte_done;
    logic       tx_cpu_wr = 0, tx_bit_adv = 0;
    logic [7:0] tx_wr_data = 0;
    logic       tx_bit, tx_not_empty, tx_byte_req;

    int total = 0;
    int bad = 0;

    // model state
    logic [7:0] m_sr = 0, m_hold = 0, m_tsr = 0, m_thold = 0;
    int         m_cnt = 0, m_st = 0, m_idx = 0, m_tst = 0;
    logic       m_done = 0, m_fresh = 0, m_ok = 1, m_req = 0;

    always #(CYC/2) clk = ~clk;

    serial_byte_buffer i_serial_byte_buffer (
        .clk(clk), .rst_n(rst_n),
        .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit), .rx_cpu_rd(rx_cpu_rd),
        .rx_dbg_rd(rx_dbg_rd), .rx_data(rx_data), .rx_overrun(rx_overrun),
        .rx_byte_done(rx_byte_done), .tx_cpu_wr(tx_cpu_wr),
        .tx_wr_data(tx_wr_data), .tx_bit_adv(tx_bit_adv), .tx_bit(tx_bit),
        .tx_not_empty(tx_not_empty), .tx_byte_req(tx_byte_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_tx_bit();
        return (m_tst == 0) ? 1'b0 : m_tsr[7 - m_idx];
    endfunction

    task automatic model_update(input logic vld, input logic b, input logic rd,
                                input logic wr, input logic [7:0] wd, input logic adv);
        logic       complete, avail;
        logic [7:0] nb, nd;
        complete = vld && (m_cnt == 7);
        nb       = {m_sr[6:0], b};
        m_done   = complete;
        case (m_st)
            0: if (complete) begin m_hold = nb; m_st = 1; end
            1: if (complete) begin
                   if (rd) m_hold = nb; else m_st = 2;
               end else if (rd) m_st = 0;
            default: if (rd) begin m_hold = complete ? nb : m_sr; m_st = 1; end
        endcase
        if (vld) begin m_sr = nb; m_cnt = (m_cnt + 1) % 8; end
        // transmit side
        avail = m_fresh | wr;
        nd    = wr ? wd : m_thold;
        if (wr) begin m_thold = wd; m_fresh = 1; m_ok = 1; end
        m_req = 0;
        if (m_tst == 0) begin
            if (avail) begin m_tsr = nd; m_fresh = 0; m_idx = 0; m_tst = 1; m_req = 1; end
        end else if (adv) begin
            if (m_idx == 7) begin
                if (avail) begin m_tsr = nd; m_fresh = 0; m_idx = 0; m_tst = 1; m_req = 1; end
                else begin m_idx = 0; m_tst = 2; m_ok = 0; end
            end else m_idx++;
        end
    endtask

    task automatic step(input logic vld, input logic b, input logic rd, input logic dbg,
                        input logic wr, input logic [7:0] wd, input logic adv);
        rx_bit_vld = vld; rx_bit = b; rx_cpu_rd = rd; rx_dbg_rd = dbg;
        tx_cpu_wr = wr; tx_wr_data = wd; tx_bit_adv = adv;
        @(posedge clk);
        model_update(vld, b, rd, wr, wd, adv);
        @(negedge clk);
        chk("R3 rx_data", rx_data, m_hold);
        chk("R2 rx_overrun", rx_overrun, (m_st == 2));
        chk("R1 rx_byte_done", rx_byte_done, m_done);
        chk("R6 tx_bit", tx_bit, exp_tx_bit());
        chk("R7 tx_not_empty", tx_not_empty, m_ok);
        chk("R9 tx_byte_req", tx_byte_req, m_req);
    endtask

    task automatic send_rx_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) step(1, v[i], 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CYC * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R5 reset values
        chk("R5 rx_data", rx_data, 0);
        chk("R5 rx_overrun", rx_overrun, 0);
        chk("R5 rx_byte_done", rx_byte_done, 0);
        chk("R5 tx_not_empty", tx_not_empty, 1);
        chk("R5 tx_bit", tx_bit, 0);
        chk("R5 tx_byte_req", tx_byte_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 capture, R2 overrun, R4 debug read ignored then CPU read drains
        send_rx_byte(8'hA5);
        chk("R1 first byte", rx_data, 8'hA5);
        send_rx_byte(8'h3C);
        chk("R2 overrun set", rx_overrun, 1);
        chk("R3 holding frozen", rx_data, 8'hA5);
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R4 debug read ignored", rx_overrun, 1);
        chk("R4 debug read ignored data", rx_data, 8'hA5);
        step(0, 0, 1, 0, 0, 0, 0);
        chk("R4 read drains", rx_data, 8'h3C);
        chk("R4 read clears overrun", rx_overrun, 0);
        step(0, 0, 1, 0, 0, 0, 0);

        // R6 start, R8 same-cycle write at boundary, R7 underflow retransmit
        step(0, 0, 0, 0, 1, 8'h96, 0);
        chk("R6 start bit7", tx_bit, 1);
        chk("R6 byte_req", tx_byte_req, 1);
        for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1, 8'h5A, 1);
        chk("R8 in-time write flag", tx_not_empty, 1);
        chk("R8 in-time write bit7", tx_bit, 0);
        chk("R8 in-time byte_req", tx_byte_req, 1);
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 1);
        chk("R7 underflow flag", tx_not_empty, 0);
        chk("R7 repeat bit7", tx_bit, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        chk("R7 repeat bit6", tx_bit, 1);
        step(0, 0, 0, 0, 1, 8'hFF, 0);
        chk("R8 write sets flag", tx_not_empty, 1);

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 2) == 0, $urandom % 2, ($urandom % 12) == 0,
                 ($urandom % 8) == 0, ($urandom % 9) == 0, 8'($urandom),
                 ($urandom % 3) != 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule